// File: doc/BRIEF.md
# Parallel-Indexed Physically-Tagged Read Cache

This block serves 32-bit virtual read addresses from a 4 KB direct-mapped cache of one-word lines. Pages are 4 KB, so the line index (address bits [11:2]) and the byte offset (bits [1:0]) both fall inside the untranslated page displacement. The cache line is therefore read in the same clock as the page number (bits [31:12]) is looked up in an 8-entry fully associative translation buffer. The line's stored 20-bit physical tag is then compared with the frame number from that buffer. Data is returned only when both agree and the line is valid.

When the translation succeeds but the line is invalid or carries another frame's tag, the block asks memory for the word at the physical address. It writes the returned word and tag into the line and completes the request as a hit. A translation miss returns a walk indication so that the full translation path can run. A translation whose access rights forbid the request returns a protection fault. A separate fill port loads translation entries. Each entry holds a page tag, a frame number, two access-right bits, a dirty bit and a reference bit. The dirty and reference bits of the matching entry are reported with each data response.

Top module: `vipt_lookup`

## Requirements
- R1: While and after synchronous reset `rst`, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A request whose page number matches no valid translation entry responds with `rsp_walk`=1 and `rsp_hit`=0, and raises no memory request.
- R3: Access rights are `perm[0]` = read allowed and `perm[1]` = user access allowed. A request with `req_user`=1 needs both bits, and one with `req_user`=0 needs `perm[0]`. A violation responds with `rsp_prot`=1 and raises no memory request.
- R4: When the translation is permitted but the line is invalid or its tag differs, `mem_req_valid` rises with `mem_req_paddr` = {frame, vaddr[11:2], 2'b00}. Both are held stable until `mem_rsp_valid` is seen.
- R5: On the clock edge where `mem_rsp_valid` is 1 during a refill, the line takes the word and the tag. In the next cycle the block responds with `rsp_hit`=1 and that word. A later read of the same line hits with no memory request.
- R6: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. Hit, walk and protection responses appear with `rsp_valid` one cycle after the next edge. Each response carries exactly one of `rsp_hit`, `rsp_walk` and `rsp_prot`.
- R7: A hit requires the stored physical tag to equal the translated frame. Two page numbers mapped to one frame share the line. A different frame at the same index misses and replaces the line.
- R8: A fill of a page number not already present goes to entries in round-robin order 0..7. The ninth new fill evicts the first one.
- R9: A fill whose page number is already resident overwrites that entry in place, with its frame, rights and dirty bit. No other entry is disturbed.
- R10: The byte offset bits [1:0] take no part in the lookup. Addresses that differ only there hit the same line.
- R11: Reset invalidates every cache line and every translation entry.
- R12: On hit responses, `rsp_page_ref` gives the entry's reference bit as it was before the request. It is 0 on the first permitted access after a fill and 1 after that. `rsp_page_dirty` gives the dirty bit loaded by the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual read address |
| req_user | input | 1 | Request made in user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Data delivered |
| rsp_walk | output | 1 | Translation missing, full translation needed |
| rsp_prot | output | 1 | Access rights forbid the request |
| rsp_data | output | 32 | Returned word |
| rsp_page_dirty | output | 1 | Dirty bit of the matching entry |
| rsp_page_ref | output | 1 | Reference bit of the matching entry before the request |
| mem_req_valid | output | 1 | Refill request to memory |
| mem_req_paddr | output | 32 | Word-aligned physical refill address |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_data | input | 32 | Refill word |
| fill_valid | input | 1 | Load a translation entry |
| fill_vpn | input | 20 | Page number of the entry |
| fill_pfn | input | 20 | Physical frame of the entry |
| fill_perm | input | 2 | Access-right bits of the entry |
| fill_dirty | input | 1 | Dirty bit of the entry |

## Verification
The assertions assume that memory returns exactly one refill word, and only while `mem_req_valid` is high. They also assume that the translation fill port never loads an entry during the same cycle in which that entry's refill is pending. The stimulus keeps to both conditions. Memory is answered only after a request is seen, and fills are issued only between requests. The stored reference and dirty bits are reached through the response flags rather than through internal state. Round-robin eviction and in-place update are judged from which later lookups still translate.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_FILL  = 2'd2
  } lk_state_e;

  localparam int PERM_RD  = 0;
  localparam int PERM_USR = 1;

  // Access is allowed when reads are permitted and, for user requests,
  // user access is permitted as well.
  function automatic logic perm_ok(input logic [1:0] perm, input logic user);
    return perm[PERM_RD] && (perm[PERM_USR] || !user);
  endfunction

endpackage

// File: rtl/xlat_buf.sv
module xlat_buf
  import vipt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_set_ref,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [1:0]       lk_perm,
  output logic             lk_dirty,
  output logic             lk_ref,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [1:0]       fill_perm,
  input  logic             fill_dirty
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, dirty_q, ref_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [1:0]         perm_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q, rr_nxt, lk_idx, fl_idx, fsel;
  logic [ENTRIES-1:0] lk_match, fl_match;
  logic               fl_resident;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
    assign fl_match[g] = valid_q[g] && (vpn_q[g] == fill_vpn);
  end

  always_comb begin
    lk_idx = '0;
    fl_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_idx = PTR_W'(i);
      if (fl_match[i]) fl_idx = PTR_W'(i);
    end
  end

  assign fl_resident = |fl_match;
  assign rr_nxt      = (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  assign fsel        = fl_resident ? fl_idx : rr_q;

  assign lk_hit   = |lk_match;
  assign lk_pfn   = pfn_q[lk_idx];
  assign lk_perm  = perm_q[lk_idx];
  assign lk_dirty = dirty_q[lk_idx];
  assign lk_ref   = ref_q[lk_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      rr_q    <= '0;
    end else begin
      if (lk_set_ref && lk_hit) ref_q[lk_idx] <= 1'b1;
      if (fill_en) begin
        valid_q[fsel] <= 1'b1;
        ref_q[fsel]   <= 1'b0;
        dirty_q[fsel] <= fill_dirty;
        if (!fl_resident) rr_q <= rr_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q[fsel]  <= fill_vpn;
      pfn_q[fsel]  <= fill_pfn;
      perm_q[fsel] <= fill_perm;
    end
  end

  // R9: a page number never matches more than one entry
  p_unique_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R9: updating a resident page does not move the replacement pointer
  p_fill_inplace_r9: assert property (@(posedge clk) disable iff (rst)
    (fill_en && fl_resident) |=> $stable(rr_q));

  // R8: a new page always lands in the slot the pointer named
  p_fill_rr_r8: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !fl_resident) |=> valid_q[$past(rr_q)]);

endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [WORD_W-1:0] data_mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= valid_q[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_idx];
      rd_data <= data_mem[rd_idx];
    end
  end

  // R11: reset leaves no line valid
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (valid_q == '0) && !rd_valid);

  // R5: a refilled line is valid afterwards
  p_write_valid_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int OFF_BITS    = 2,
  parameter int PFN_W       = 20,
  parameter int WORD_W      = 32,
  parameter int TLB_ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic                       req_user,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic                       rsp_walk,
  output logic                       rsp_prot,
  output logic [WORD_W-1:0]          rsp_data,
  output logic                       rsp_page_dirty,
  output logic                       rsp_page_ref,
  output logic                       mem_req_valid,
  output logic [PFN_W+PAGE_BITS-1:0] mem_req_paddr,
  input  logic                       mem_rsp_valid,
  input  logic [WORD_W-1:0]          mem_rsp_data,
  input  logic                       fill_valid,
  input  logic [VA_W-PAGE_BITS-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]           fill_pfn,
  input  logic [1:0]                 fill_perm,
  input  logic                       fill_dirty
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int IDX_W = PAGE_BITS - OFF_BITS;
  localparam int PA_W  = PFN_W + PAGE_BITS;

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return VPN_W'(va >> PAGE_BITS);
  endfunction

  function automatic logic [IDX_W-1:0] line_of(input logic [VA_W-1:0] va);
    return IDX_W'(va >> OFF_BITS);
  endfunction

  function automatic logic [PA_W-1:0] phys_of(input logic [PFN_W-1:0] pfn,
                                              input logic [IDX_W-1:0] idx);
    return {pfn, idx, {OFF_BITS{1'b0}}};
  endfunction

  lk_state_e         state;
  logic [IDX_W-1:0]  idx_q;
  logic [PFN_W-1:0]  t_pfn_q;
  logic              t_hit_q, t_ok_q, t_dirty_q, t_ref_q;

  logic              lk_hit, lk_dirty, lk_ref;
  logic [PFN_W-1:0]  lk_pfn;
  logic [1:0]        lk_perm;
  logic              line_valid;
  logic [PFN_W-1:0]  line_tag;
  logic [WORD_W-1:0] line_data;

  // Named internal events
  logic ev_accept, in_check, ev_xmiss, ev_prot, ev_tag_hit;
  logic ev_refill_start, ev_refill_done;

  assign req_ready       = (state == ST_IDLE);
  assign ev_accept       = req_ready && req_valid;
  assign in_check        = (state == ST_CHECK);
  assign ev_xmiss        = in_check && !t_hit_q;
  assign ev_prot         = in_check && t_hit_q && !t_ok_q;
  assign ev_tag_hit      = in_check && t_hit_q && t_ok_q && line_valid && (line_tag == t_pfn_q);
  assign ev_refill_start = in_check && t_hit_q && t_ok_q && !ev_tag_hit;
  assign ev_refill_done  = (state == ST_FILL) && mem_rsp_valid;

  xlat_buf #(
    .ENTRIES (TLB_ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) u_xlat (
    .clk        (clk),
    .rst        (rst),
    .lk_vpn     (page_of(req_vaddr)),
    .lk_set_ref (ev_accept && perm_ok(lk_perm, req_user)),
    .lk_hit     (lk_hit),
    .lk_pfn     (lk_pfn),
    .lk_perm    (lk_perm),
    .lk_dirty   (lk_dirty),
    .lk_ref     (lk_ref),
    .fill_en    (fill_valid),
    .fill_vpn   (fill_vpn),
    .fill_pfn   (fill_pfn),
    .fill_perm  (fill_perm),
    .fill_dirty (fill_dirty)
  );

  line_store #(
    .IDX_W  (IDX_W),
    .TAG_W  (PFN_W),
    .WORD_W (WORD_W)
  ) u_lines (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (ev_accept),
    .rd_idx   (line_of(req_vaddr)),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .rd_data  (line_data),
    .wr_en    (ev_refill_done),
    .wr_idx   (idx_q),
    .wr_tag   (t_pfn_q),
    .wr_data  (mem_rsp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_walk       <= 1'b0;
      rsp_prot       <= 1'b0;
      rsp_data       <= '0;
      rsp_page_dirty <= 1'b0;
      rsp_page_ref   <= 1'b0;
      mem_req_valid  <= 1'b0;
      mem_req_paddr  <= '0;
      idx_q          <= '0;
      t_pfn_q        <= '0;
      t_hit_q        <= 1'b0;
      t_ok_q         <= 1'b0;
      t_dirty_q      <= 1'b0;
      t_ref_q        <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_walk  <= 1'b0;
      rsp_prot  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            idx_q     <= line_of(req_vaddr);
            t_hit_q   <= lk_hit;
            t_ok_q    <= perm_ok(lk_perm, req_user);
            t_pfn_q   <= lk_pfn;
            t_dirty_q <= lk_dirty;
            t_ref_q   <= lk_ref;
            state     <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          state <= ST_IDLE;
          if (ev_xmiss || ev_prot) begin
            rsp_valid      <= 1'b1;
            rsp_walk       <= ev_xmiss;
            rsp_prot       <= ev_prot;
            rsp_data       <= '0;
            rsp_page_dirty <= 1'b0;
            rsp_page_ref   <= 1'b0;
          end else if (ev_tag_hit) begin
            rsp_valid      <= 1'b1;
            rsp_hit        <= 1'b1;
            rsp_data       <= line_data;
            rsp_page_dirty <= t_dirty_q;
            rsp_page_ref   <= t_ref_q;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_paddr <= phys_of(t_pfn_q, idx_q);
            state         <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rsp_valid) begin
            mem_req_valid  <= 1'b0;
            rsp_valid      <= 1'b1;
            rsp_hit        <= 1'b1;
            rsp_data       <= mem_rsp_data;
            rsp_page_dirty <= t_dirty_q;
            rsp_page_ref   <= t_ref_q;
            state          <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: the block is idle and quiet right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> req_ready && !rsp_valid && !mem_req_valid);

  // R2: a translation miss answers with a walk and no memory traffic
  p_walk_r2: assert property (@(posedge clk) disable iff (rst)
    ev_xmiss |=> rsp_valid && rsp_walk && !mem_req_valid);

  // R3: forbidden access answers with a fault and no memory traffic
  p_prot_r3: assert property (@(posedge clk) disable iff (rst)
    ev_prot |=> rsp_valid && rsp_prot && !mem_req_valid);

  // R4: refill request and address held until memory answers
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_rsp_valid) |=> mem_req_valid && $stable(mem_req_paddr));

  // R4: a refill starts whenever the permitted lookup misses the line
  p_refill_start_r4: assert property (@(posedge clk) disable iff (rst)
    ev_refill_start |=> mem_req_valid && !rsp_valid);

  // R5: an answered refill completes as a hit
  p_refill_hit_r5: assert property (@(posedge clk) disable iff (rst)
    ev_refill_done |=> rsp_valid && rsp_hit && !mem_req_valid);

  // R6: two edges after acceptance either a response or a refill is out
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    ev_accept |=> ##1 (rsp_valid || mem_req_valid));

  // R6: every response has exactly one outcome
  p_one_kind_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_walk, rsp_prot}) == 1);

  // R7: a hit response from the lookup stage carries the stored line word
  p_tag_hit_r7: assert property (@(posedge clk) disable iff (rst)
    ev_tag_hit |=> rsp_valid && rsp_hit && (rsp_data == $past(line_data)));

endmodule

// File: tb/tb_vipt_lookup.sv
`timescale 1ns/1ps
module tb_vipt_lookup;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_walk, rsp_prot;
  logic [31:0] rsp_data;
  logic        rsp_page_dirty, rsp_page_ref;
  logic        mem_req_valid;
  logic [31:0] mem_req_paddr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [1:0]  fill_perm = '0;
  logic        fill_dirty = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  vipt_lookup dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_walk(rsp_walk), .rsp_prot(rsp_prot),
    .rsp_data(rsp_data), .rsp_page_dirty(rsp_page_dirty), .rsp_page_ref(rsp_page_ref),
    .mem_req_valid(mem_req_valid), .mem_req_paddr(mem_req_paddr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .fill_dirty(fill_dirty)
  );

  // Memory content as a function of the physical address.
  function automatic logic [31:0] memw(input logic [31:0] pa);
    return {pa[15:0], ~pa[31:16]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tlb_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                          input logic [1:0] perm, input logic dirty);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm; fill_dirty = dirty;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // Vector: {vaddr, user, class, dirty, ref, paddr}; class 0 hit, 1 refill, 2 walk, 3 fault
  task automatic run_vec(input logic [68:0] v, input string req, input int lag);
    logic [31:0] va, pa, got_pa;
    logic        u, ed, er;
    logic [1:0]  cls;
    logic [2:0]  kind_exp;
    int          cyc, waited;
    bit          sent, held;
    {va, u, cls, ed, er, pa} = v;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; sent = 0; held = 1; waited = 0; got_pa = '0;
    while (!rsp_valid && cyc < 40) begin
      if (mem_req_valid) begin
        if (!sent) begin
          sent = 1; got_pa = mem_req_paddr;
        end else if (mem_req_paddr != got_pa) begin
          held = 0;
        end
        if (waited == lag) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = memw(mem_req_paddr);
        end
        waited++;
      end else if (sent) begin
        held = (waited > lag) ? held : 1'b0;
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      cyc++;
    end
    kind_exp = (cls <= 2'd1) ? 3'b100 : (cls == 2'd2) ? 3'b010 : 3'b001;
    chk(rsp_valid == 1'b1, {req, " response present (R6)"}, 32'(rsp_valid), 32'd1);
    chk({rsp_hit, rsp_walk, rsp_prot} == kind_exp, {req, " outcome hit/walk/fault"},
        32'({rsp_hit, rsp_walk, rsp_prot}), 32'(kind_exp));
    chk(cyc == ((cls == 2'd1) ? 3 + lag : 2), {req, " latency (R6)"}, 32'(cyc),
        32'((cls == 2'd1) ? 3 + lag : 2));
    chk(sent == (cls == 2'd1), {req, " memory request raised (R4)"}, 32'(sent), 32'(cls == 2'd1));
    if (cls == 2'd1) begin
      chk(got_pa == pa, {req, " refill address (R4)"}, got_pa, pa);
      chk(held, {req, " request held until answered (R4)"}, 32'(held), 32'd1);
    end
    if (cls <= 2'd1) begin
      chk(rsp_data == memw(pa), {req, " data (R5)"}, rsp_data, memw(pa));
      chk({rsp_page_dirty, rsp_page_ref} == {ed, er}, {req, " dirty/ref flags (R12)"},
          32'({rsp_page_dirty, rsp_page_ref}), 32'({ed, er}));
    end
  endtask

  task automatic check_idle(input string req);
    chk(req_ready == 1'b1, {req, " ready after reset"}, 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, {req, " no response after reset"}, 32'(rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, {req, " no refill after reset"}, 32'(mem_req_valid), 32'd0);
  endtask

  localparam logic [68:0] VEC [12] = '{
    {32'h0001_0123, 1'b1, 2'd1, 1'b1, 1'b0, 32'h0010_0120},  // R4 R5 cold line
    {32'h0001_0123, 1'b1, 2'd0, 1'b1, 1'b1, 32'h0010_0120},  // R5 R12 now resident
    {32'h0002_0121, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0010_0120},  // R7 synonym, R10 offset
    {32'h0003_0400, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0020_0400},  // R4 supervisor page
    {32'h0003_0400, 1'b1, 2'd3, 1'b0, 1'b0, 32'h0000_0000},  // R3 user denied
    {32'h0003_0400, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0020_0400},  // R12 ref set
    {32'h0004_0000, 1'b0, 2'd3, 1'b0, 1'b0, 32'h0000_0000},  // R3 no read right
    {32'h0005_0000, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0000_0000},  // R2 untranslated
    {32'h0001_0400, 1'b0, 2'd1, 1'b1, 1'b1, 32'h0010_0400},  // R7 conflict replaces
    {32'h0003_0400, 1'b0, 2'd1, 1'b0, 1'b1, 32'h0020_0400},  // R7 evicted line misses
    {32'h0001_0124, 1'b1, 2'd1, 1'b1, 1'b1, 32'h0010_0124},  // R4 next line
    {32'h0001_0126, 1'b1, 2'd0, 1'b1, 1'b1, 32'h0010_0124}   // R10 byte offset ignored
  };

  initial begin
    #800000;
    n_fails++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");
    run_vec({32'h0001_0123, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0}, "R1 empty buffer walks", 0);

    tlb_fill(20'h00010, 20'h00100, 2'b11, 1'b1);
    tlb_fill(20'h00020, 20'h00100, 2'b11, 1'b0);
    tlb_fill(20'h00030, 20'h00200, 2'b01, 1'b0);
    tlb_fill(20'h00040, 20'h00300, 2'b00, 1'b0);

    for (int i = 0; i < 12; i++) run_vec(VEC[i], $sformatf("vector %0d", i), 0);

    // R4: slow memory, request must stay put
    run_vec({32'h0001_0800, 1'b0, 2'd1, 1'b1, 1'b1, 32'h0010_0800}, "R4 slow refill", 4);

    // R8: five more new pages fill slots 4..7 then wrap onto slot 0
    for (int k = 0; k < 5; k++) tlb_fill(20'h00100 + 20'(k), 20'h00700 + 20'(k), 2'b11, 1'b0);
    run_vec({32'h0001_0123, 1'b1, 2'd2, 1'b0, 1'b0, 32'h0}, "R8 oldest entry evicted", 0);
    run_vec({32'h0010_4000, 1'b1, 2'd1, 1'b0, 1'b0, 32'h0070_4000}, "R8 newest entry present", 0);
    run_vec({32'h0002_0121, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0010_0120}, "R8 second entry kept", 0);

    // R9: rewrite a resident page; no other entry may be displaced
    tlb_fill(20'h00030, 20'h00600, 2'b11, 1'b1);
    run_vec({32'h0003_0400, 1'b1, 2'd1, 1'b1, 1'b0, 32'h0060_0400}, "R9 updated in place", 0);
    run_vec({32'h0002_0121, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0010_0120}, "R9 neighbour untouched", 0);

    // R11: reset clears both structures
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    check_idle("R1 R11");
    run_vec({32'h0002_0121, 1'b1, 2'd2, 1'b0, 1'b0, 32'h0}, "R11 translations cleared", 0);
    tlb_fill(20'h00020, 20'h00100, 2'b11, 1'b0);
    run_vec({32'h0002_0121, 1'b1, 2'd1, 1'b0, 1'b0, 32'h0010_0120}, "R11 lines cleared", 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule